// File: doc/BRIEF.md
# Endian-Selectable Memory Access Unit

This unit connects a 32-bit core to a local byte-organised RAM of 2^P bytes. A request carries a direction, a size (byte, halfword or word), an address, write data and a flag that asks for a signed load. The unit places bytes into the RAM in little-endian or big-endian order, chosen by a configuration input. It returns loaded data extended to 32 bits, and it raises a bus-error flag when an access is illegal.

Legality is decided by one mask per access size. The mask for a byte covers the whole RAM. The mask for a halfword also clears bit 0, and the mask for a word clears bits 1:0. Any address bit outside the mask marks the access as faulting. This one test catches both misaligned addresses and addresses beyond the RAM.

Byte writes above a fixed I/O threshold are treated as device accesses and never fault. They are written into the RAM at the masked address. When the address equals the transmit register, the byte is also sent out on a serial-transmit side port, except for a carriage return.

Top module: `endian_mem_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, rdata, bus_err, io_valid and io_data are all zero.
- R2: With big_endian=0, a word write stores bits 7:0 at RAM offset 0, bits 15:8 at offset 1, bits 23:16 at offset 2 and bits 31:24 at offset 3. A word read assembles the bytes in the same order.
- R3: With big_endian=1, a word write stores bits 31:24 at offset 0, down to bits 7:0 at offset 3. A word read assembles the bytes in the same order.
- R4: A halfword access follows the endian rule over offsets 0 and 1. With big_endian=0, the low byte is at offset 0. With big_endian=1, the high byte is at offset 0.
- R5: A byte access reads or writes data bits 7:0 at the addressed byte, identically in both endian modes.
- R6: size encoding: 0 is byte, 1 is halfword, 2 is word, and 3 is reserved. A halfword with address bit 0 set, or a word with either of address bits 1:0 set, raises bus_err.
- R7: An access with any address bit at position P or above set raises bus_err, unless R10 applies. Size 3 always raises bus_err.
- R8: A faulting write leaves the RAM unchanged. A faulting read returns rdata = 0.
- R9: With sign_ext=1, a byte load sign-extends bit 7 and a halfword load sign-extends bit 15. With sign_ext=0, both loads are zero-extended. A word load ignores sign_ext.
- R10: A byte write whose address is strictly greater than IO_BASE (default 0x0500_0000) does not fault, and it writes the RAM at address & (2^P-1). A byte write at exactly IO_BASE is checked as in R7.
- R11: A byte write to TX_ADDR (default 0x05FF_FECB) whose data is not 0x0D pulses io_valid for one cycle, with io_data equal to that byte, in the cycle after the request. A 0x0D byte, or any other address, produces no pulse, and io_data keeps its value.
- R12: bus_err and rdata are registered and valid in the cycle after req. bus_err is zero in any cycle that does not follow a request. rdata changes only after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects big-endian byte order |
| req | input | 1 | Request strobe, one cycle per access |
| we | input | 1 | 1 write, 0 read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| sign_ext | input | 1 | Sign-extend byte and halfword loads |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Load result, cycle after req |
| bus_err | output | 1 | Fault flag, cycle after req |
| io_valid | output | 1 | Transmit byte strobe |
| io_data | output | 8 | Transmit byte |

## Verification
The bench checks byte placement by writing whole words and halfwords and reading them back one byte at a time, in both endian modes. A swapped lane map would show up there as permuted bytes. It also probes the fault boundaries: each misaligned offset, the first address past the RAM, the reserved size, and a byte write exactly at the I/O threshold compared with one just above it. A design that checked alignment alone would accept the out-of-range accesses, and a threshold test written as >= would let the boundary write through. After every faulting write, the bench reads the location back; a design that wrote anyway would return the new data. On the transmit register, the bench sends both an ordinary byte and a carriage return and expects exactly one strobe.

// File: rtl/emu_pkg.sv
package emu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } emu_size_e;

   localparam int LANES = 4;
endpackage

// File: rtl/emu_addr_check.sv
module emu_addr_check
   import emu_pkg::*;
#(
   parameter int          P        = 10,
   parameter int          AW       = 32,
   parameter logic [31:0] IO_BASE  = 32'h0500_0000,
   parameter logic [31:0] TX_ADDR  = 32'h05FF_FECB
) (
   input  logic [AW-1:0] addr,
   input  emu_size_e     size,
   input  logic          we,
   output logic          fault,
   output logic [P-1:0]  idx,
   output logic          tx_hit
);
   localparam logic [AW-1:0] FULL_MASK = {{(AW-P){1'b0}}, {P{1'b1}}};

   logic [AW-1:0] mask;
   logic          io_win;
   logic          raw_fault;

   always_comb begin
      unique case (size)
         SZ_BYTE: mask = FULL_MASK;
         SZ_HALF: mask = FULL_MASK & ~AW'(1);
         SZ_WORD: mask = FULL_MASK & ~AW'(3);
         default: mask = '0;
      endcase
   end

   assign io_win    = (size == SZ_BYTE) && we && (addr > AW'(IO_BASE));
   assign raw_fault = (size == SZ_RSVD) || ((addr & ~mask) != '0);
   assign fault     = raw_fault && !io_win;
   assign idx       = addr[P-1:0] & mask[P-1:0];
   assign tx_hit    = io_win && (addr == AW'(TX_ADDR));
endmodule

// File: rtl/emu_store_steer.sv
module emu_store_steer
   import emu_pkg::*;
(
   input  emu_size_e         size,
   input  logic              big_endian,
   input  logic [31:0]       wdata,
   output logic [LANES-1:0]  lane_en,
   output logic [LANES-1:0][7:0] lane_data
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               lane_en[k]   = (k == 0);
               lane_data[k] = wdata[7:0];
            end
            SZ_HALF: begin
               lane_en[k]   = (k < 2);
               lane_data[k] = big_endian ? wdata[8*((1-k)&1) +: 8] : wdata[8*(k&1) +: 8];
            end
            SZ_WORD: begin
               lane_en[k]   = 1'b1;
               lane_data[k] = big_endian ? wdata[8*(LANES-1-k) +: 8] : wdata[8*k +: 8];
            end
            default: begin
               lane_en[k]   = 1'b0;
               lane_data[k] = 8'h00;
            end
         endcase
      end
   end
endmodule

// File: rtl/emu_load_fmt.sv
module emu_load_fmt
   import emu_pkg::*;
(
   input  emu_size_e             size,
   input  logic                  big_endian,
   input  logic                  sign_ext,
   input  logic [LANES-1:0][7:0] lanes,
   output logic [31:0]           data
);
   logic [15:0] half_v;
   logic [31:0] word_v;

   assign half_v = big_endian ? {lanes[0], lanes[1]} : {lanes[1], lanes[0]};
   assign word_v = big_endian ? {lanes[0], lanes[1], lanes[2], lanes[3]}
                              : {lanes[3], lanes[2], lanes[1], lanes[0]};

   always_comb begin
      unique case (size)
         SZ_BYTE: data = {{24{sign_ext & lanes[0][7]}}, lanes[0]};
         SZ_HALF: data = {{16{sign_ext & half_v[15]}}, half_v};
         SZ_WORD: data = word_v;
         default: data = '0;
      endcase
   end
endmodule

// File: rtl/endian_mem_unit.sv
module endian_mem_unit
   import emu_pkg::*;
#(
   parameter int          P       = 10,
   parameter logic [31:0] IO_BASE = 32'h0500_0000,
   parameter logic [31:0] TX_ADDR = 32'h05FF_FECB
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        big_endian,
   input  logic        req,
   input  logic        we,
   input  logic [1:0]  size,
   input  logic        sign_ext,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        bus_err,
   output logic        io_valid,
   output logic [7:0]  io_data
);
   localparam int RAM_BYTES = 1 << P;
   localparam logic [7:0] CR_CODE = 8'h0D;

   if (P < 2 || P > 16) begin : g_bad_p
      $error("endian_mem_unit: P must lie in 2..16");
   end
   if (TX_ADDR <= IO_BASE) begin : g_bad_tx
      $error("endian_mem_unit: TX_ADDR must be above IO_BASE");
   end

   emu_size_e             sz;
   logic                  fault;
   logic [P-1:0]          idx;
   logic                  tx_hit;
   logic [LANES-1:0]      lane_en;
   logic [LANES-1:0][7:0] lane_data;
   logic [LANES-1:0][7:0] rd_lanes;
   logic [31:0]           rd_val;
   logic [7:0]            mem [RAM_BYTES];

   assign sz = emu_size_e'(size);

   emu_addr_check #(.P(P), .AW(32), .IO_BASE(IO_BASE), .TX_ADDR(TX_ADDR)) u_chk (
      .addr   (addr),
      .size   (sz),
      .we     (we),
      .fault  (fault),
      .idx    (idx),
      .tx_hit (tx_hit)
   );

   emu_store_steer u_steer (
      .size       (sz),
      .big_endian (big_endian),
      .wdata      (wdata),
      .lane_en    (lane_en),
      .lane_data  (lane_data)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_rd
      assign rd_lanes[k] = mem[idx + P'(k)];
   end

   emu_load_fmt u_fmt (
      .size       (sz),
      .big_endian (big_endian),
      .sign_ext   (sign_ext),
      .lanes      (rd_lanes),
      .data       (rd_val)
   );

   always_ff @(posedge clk) begin
      if (req && we && !fault) begin
         for (int k = 0; k < LANES; k++) begin
            if (lane_en[k]) mem[idx + P'(k)] <= lane_data[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         bus_err  <= 1'b0;
         io_valid <= 1'b0;
         io_data  <= '0;
      end else begin
         bus_err  <= req && fault;
         io_valid <= req && tx_hit && (wdata[7:0] != CR_CODE);
         if (req && tx_hit && (wdata[7:0] != CR_CODE)) io_data <= wdata[7:0];
         if (req && !we) rdata <= fault ? 32'h0 : rd_val;
      end
   end

   AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(req)); // R12
   AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (req && fault) |=> bus_err); // R6
   AST_WRITE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we) |=> $stable(rdata)); // R12
   AST_IO_NO_CR: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> (io_data != CR_CODE)); // R11
   AST_IO_FROM_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> $past(req && we && size == 2'd0)); // R11
endmodule

// File: tb/endian_mem_unit_tb_top.sv
module endian_mem_unit_tb_top;
   localparam int          P       = 10;
   localparam int          NB      = 1 << P;
   localparam logic [31:0] IO_BASE = 32'h0500_0000;
   localparam logic [31:0] TX_ADDR = 32'h05FF_FECB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  size = 2'd0;
   logic        sign_ext = 1'b0;
   logic [31:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        bus_err;
   logic        io_valid;
   logic [7:0]  io_data;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]  ref_mem [NB];
   logic [31:0] e_rdata = '0;
   logic [7:0]  e_io_data = '0;

   always #5 clk = ~clk;

   endian_mem_unit #(.P(P), .IO_BASE(IO_BASE), .TX_ADDR(TX_ADDR)) dut_i (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req(req), .we(we),
      .size(size), .sign_ext(sign_ext), .addr(addr), .wdata(wdata),
      .rdata(rdata), .bus_err(bus_err), .io_valid(io_valid), .io_data(io_data)
   );

   function automatic bit m_fault(input bit w, input logic [1:0] s, input logic [31:0] a);
      logic [31:0] msk;
      if (s == 2'd0 && w && a > IO_BASE) return 1'b0;
      if (s == 2'd3) return 1'b1;
      msk = (s == 2'd0) ? 32'h3FF : (s == 2'd1) ? 32'h3FE : 32'h3FC;
      return (a & ~msk) != 0;
   endfunction

   function automatic logic [31:0] m_read(input logic [1:0] s, input logic [31:0] a,
                                          input bit be, input bit sx);
      int i;
      logic [15:0] h;
      i = int'(a & 32'h3FF);
      case (s)
         2'd0: return sx ? {{24{ref_mem[i][7]}}, ref_mem[i]} : {24'h0, ref_mem[i]};
         2'd1: begin
            h = be ? {ref_mem[i], ref_mem[i+1]} : {ref_mem[i+1], ref_mem[i]};
            return sx ? {{16{h[15]}}, h} : {16'h0, h};
         end
         default: return be ? {ref_mem[i], ref_mem[i+1], ref_mem[i+2], ref_mem[i+3]}
                            : {ref_mem[i+3], ref_mem[i+2], ref_mem[i+1], ref_mem[i]};
      endcase
   endfunction

   task automatic m_write(input logic [1:0] s, input logic [31:0] a, input logic [31:0] d,
                          input bit be);
      int i;
      i = int'(a & 32'h3FF);
      case (s)
         2'd0: ref_mem[i] = d[7:0];
         2'd1: if (be) begin ref_mem[i] = d[15:8]; ref_mem[i+1] = d[7:0]; end
               else    begin ref_mem[i] = d[7:0];  ref_mem[i+1] = d[15:8]; end
         default:
            for (int k = 0; k < 4; k++) ref_mem[i+k] = be ? d[8*(3-k) +: 8] : d[8*k +: 8];
      endcase
   endtask

   task automatic cmp(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag, input bit e_err, input bit e_iov);
      cmp(tag, "rdata", rdata, e_rdata);
      cmp(tag, "bus_err", {31'h0, bus_err}, {31'h0, e_err});
      cmp(tag, "io_valid", {31'h0, io_valid}, {31'h0, e_iov});
      cmp(tag, "io_data", {24'h0, io_data}, {24'h0, e_io_data});
   endtask

   task automatic op(input string tag, input bit w, input logic [1:0] s,
                     input logic [31:0] a, input logic [31:0] d, input bit sx);
      bit f, iov;
      req = 1'b1; we = w; size = s; addr = a; wdata = d; sign_ext = sx;
      f   = m_fault(w, s, a);
      iov = w && s == 2'd0 && a == TX_ADDR && d[7:0] != 8'h0D;
      if (!w) e_rdata = f ? 32'h0 : m_read(s, a, big_endian, sx);
      if (iov) e_io_data = d[7:0];
      @(posedge clk);
      if (w && !f) m_write(s, a, d, big_endian);
      @(negedge clk);
      req = 1'b0;
      cmp_all(tag, f, iov);
   endtask

   task automatic idle(input string tag);
      req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cmp_all(tag, 1'b0, 1'b0);
   endtask

   initial begin
      #(10 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_all("R1", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("R1", 1'b0, 1'b0);

      // preload low region and top word, little-endian
      for (int a = 0; a < 128; a += 4) op("R2", 1, 2'd2, a, 32'h1000_0000 * (a % 7) + 32'h0102_0304 + a, 0);
      op("R2", 1, 2'd2, 32'h3FC, 32'hCAFE_F00D, 0);
      op("R2", 1, 2'd2, 32'h10, 32'hA1B2_C3D4, 0);
      for (int k = 0; k < 4; k++) op("R2", 0, 2'd0, 32'h10 + k, 0, 0);
      op("R2", 0, 2'd2, 32'h10, 0, 0);
      op("R2", 0, 2'd2, 32'h3FC, 0, 0);
      op("R4", 0, 2'd1, 32'h12, 0, 0);
      op("R9", 0, 2'd1, 32'h12, 0, 1);
      op("R9", 0, 2'd1, 32'h10, 0, 1);
      op("R9", 0, 2'd0, 32'h13, 0, 1);
      op("R9", 0, 2'd0, 32'h13, 0, 0);
      op("R9", 0, 2'd2, 32'h10, 0, 1);
      op("R4", 1, 2'd1, 32'h18, 32'h0000_BEEF, 0);
      op("R4", 0, 2'd0, 32'h18, 0, 0);
      op("R4", 0, 2'd0, 32'h19, 0, 0);
      op("R5", 1, 2'd0, 32'h40, 32'hFFFF_FF5A, 0);
      op("R5", 0, 2'd0, 32'h40, 0, 0);

      big_endian = 1'b1;
      op("R3", 1, 2'd2, 32'h20, 32'h8899_AABB, 0);
      for (int k = 0; k < 4; k++) op("R3", 0, 2'd0, 32'h20 + k, 0, 0);
      op("R3", 0, 2'd2, 32'h20, 0, 0);
      op("R3", 0, 2'd2, 32'h10, 0, 0);
      op("R4", 1, 2'd1, 32'h30, 32'h1234_F00D, 0);
      op("R4", 0, 2'd0, 32'h30, 0, 0);
      op("R4", 0, 2'd0, 32'h31, 0, 0);
      op("R4", 0, 2'd1, 32'h30, 0, 1);
      op("R9", 0, 2'd1, 32'h22, 0, 1);
      op("R5", 0, 2'd0, 32'h40, 0, 0);
      op("R5", 1, 2'd0, 32'h41, 32'h0000_00C3, 0);
      op("R5", 0, 2'd0, 32'h41, 0, 1);

      op("R6", 0, 2'd1, 32'h5, 0, 0);
      op("R6", 0, 2'd2, 32'h2, 0, 0);
      op("R6", 0, 2'd2, 32'h1, 0, 0);
      op("R6", 1, 2'd2, 32'h23, 32'hDEAD_DEAD, 0);
      op("R8", 0, 2'd2, 32'h20, 0, 0);
      op("R7", 0, 2'd2, 32'h400, 0, 0);
      op("R7", 0, 2'd0, 32'h1000, 0, 0);
      op("R7", 0, 2'd3, 32'h0, 0, 0);
      op("R7", 1, 2'd1, 32'h0500_0102, 32'h7777, 0);
      op("R8", 1, 2'd2, 32'h410, 32'h5555_5555, 0);
      op("R8", 0, 2'd2, 32'h10, 0, 0);
      op("R8", 1, 2'd3, 32'h20, 32'h0, 0);
      op("R8", 0, 2'd2, 32'h20, 0, 0);
      idle("R12");

      op("R10", 1, 2'd0, 32'h0500_0100, 32'h0000_0066, 0);
      op("R10", 0, 2'd0, 32'h100, 0, 0);
      op("R10", 1, 2'd0, IO_BASE, 32'h0000_0011, 0);
      op("R10", 0, 2'd0, IO_BASE, 0, 0);
      op("R11", 1, 2'd0, TX_ADDR, 32'h0000_0041, 0);
      idle("R11");
      op("R11", 1, 2'd0, TX_ADDR, 32'h0000_000D, 0);
      op("R11", 1, 2'd0, TX_ADDR + 2, 32'h0000_0042, 0);
      op("R10", 0, 2'd0, TX_ADDR & 32'h3FF, 0, 0);
      op("R11", 1, 2'd0, TX_ADDR, 32'h0000_007A, 0);
      op("R12", 1, 2'd2, 32'h44, 32'h0BAD_F00D, 0);
      idle("R12");
      idle("R12");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule